// File: doc/BRIEF.md
# Serial Receive Holding Queue

This block sits between the bit-level deserializer of a 16550-style serial port and the register bus. Each time the deserializer finishes a character it presents the character together with its parity-error, framing-error and break indications. The block keeps these entries in first-in first-out order and shows the oldest one to software through a read-only data register at byte offset 0. That register can be reached only while the divisor-latch select bit is low. A write to the same offset with the select low is forwarded to the transmit side.

The line status register gives the error flags of the character at the head of the queue, which is the character the next data read will return. Software reads the status register first and then the data register, and it gets a matching pair for one character. The block also reports a data-ready level. It raises a sticky overrun flag when a character arrives while the queue has no free entry; that character is dropped. Characters configured shorter than 8 bits come back with their unused upper bits cleared. A queue-clear input empties the queue in a single cycle.

Top module: `rx_holding_queue`

## Requirements
- R1: After a synchronous reset, data_ready and overrun are 0 and a line status read returns 0.
- R2: A read at offset 0x00 with dl_sel low returns the oldest queued character in bits 7:0, with bit 0 being the first data bit received. Bits 31:8 read as zero. The read removes that entry from the queue.
- R3: char_len selects the character length. Code 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8, sampled when the character is accepted. Data bits at or above the length read as zero.
- R4: With dl_sel high, a read at offset 0x00 returns zero and removes nothing. A write at offset 0x00 with dl_sel low pulses tx_wr in the same cycle with tx_byte equal to the written byte and leaves the queue unchanged. With dl_sel high it does not pulse tx_wr.
- R5: A read at offset 0x14 returns the line status: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break. Bits 2 to 4 belong to the head character and are zero when the queue is empty. All other bits read as zero.
- R6: data_ready is high exactly while the queue holds at least one character.
- R7: The queue holds 16 characters. A character that arrives while all 16 entries are in use and no entry is being removed is dropped, the stored entries are kept, and overrun is set from the next cycle.
- R8: A character that arrives in the same cycle as a data read of a full queue is accepted and does not set overrun.
- R9: Overrun stays set until a line status read, which clears it from the next cycle. If a drop happens in the same cycle as that read, overrun stays set.
- R10: fifo_clr empties the queue by the next cycle. A character that arrives in the same cycle is discarded without setting overrun, and the overrun flag is not changed by the clear.
- R11: A data read of an empty queue returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Empties the queue in one cycle |
| char_len | input | 2 | Character length code, 0 to 3 for 5 to 8 bits |
| rx_valid | input | 1 | Deserializer presents a finished character |
| rx_data | input | 8 | Received character, first bit in bit 0 |
| rx_perr | input | 1 | Parity error of that character |
| rx_ferr | input | 1 | Framing error of that character |
| rx_brk | input | 1 | Break indication of that character |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| dl_sel | input | 1 | Divisor-latch select bit from the line control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| tx_wr | output | 1 | Write forwarded to the transmit path |
| tx_byte | output | 8 | Byte forwarded to the transmit path |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two cases can fall in the same cycle. A new character can arrive while a data read removes the head of a full queue, and a drop can happen in the same cycle as the line status read that would clear overrun. The bench fills the queue to exactly 16 entries and then issues one cycle that has both a data read and a new character. It expects overrun to stay low and expects every character to come back in order. It then overfills the queue and issues a status read together with one more arrival, and it expects the flag to stay set. Random traffic with a fixed seed produces these collisions again, and each one is judged against a reference queue model kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int MIN_LEN = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LSR  = 8'h14;

    // one queued character with its own error flags
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // line status layout, bit 0 is data ready
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
        logic ovr;
        logic dr;
    } lsr_t;

    localparam int LSR_W = $bits(lsr_t);

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_LSR  = 2'd2
    } rd_sel_e;

    // mask of valid data bits for a length code
    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] code);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_LEN + int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      drop
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [IDX_W-1:0] wptr;
    logic [IDX_W-1:0] rptr;
    logic [CNT_W-1:0] cnt;
    logic             pop_ok;
    logic             push_ok;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign pop_ok  = pop && !empty && !clr;
    // a removal in the same cycle frees the slot for the arrival
    assign push_ok = push && !clr && (!full || pop_ok);
    assign drop    = push && !clr && full && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= next_idx(wptr);
            if (pop_ok)  rptr <= next_idx(rptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wr_entry;
    end

    assign head = empty ? '0 : mem[rptr];

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
        drop |=> full);

    a_r8_swap_stays_full: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full && !clr) |=> full);

    a_r10_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic lsr_rd,
    output logic ovr
);

    always_ff @(posedge clk) begin
        if (rst)         ovr <= 1'b0;
        else if (drop)   ovr <= 1'b1;   // a new loss beats the clearing read
        else if (lsr_rd) ovr <= 1'b0;
    end

    a_r9_set_on_drop: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr);

    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !drop) |=> !ovr);

endmodule

// File: rtl/rxq_regport.sv
module rxq_regport
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dl_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  rx_entry_t         head,
    input  logic              empty,
    input  logic              ovr,
    output logic [BUS_W-1:0]  rd_data,
    output logic              pop,
    output logic              lsr_rd,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_data
);

    logic    hit_data;
    rd_sel_e sel;
    lsr_t    lsr;

    assign hit_data = (addr == OFS_DATA) && !dl_sel;

    always_comb begin
        sel = SEL_NONE;
        if (rd_en) begin
            if (hit_data)             sel = SEL_DATA;
            else if (addr == OFS_LSR) sel = SEL_LSR;
        end
    end

    assign pop     = (sel == SEL_DATA);
    assign lsr_rd  = (sel == SEL_LSR);
    assign tx_wr   = wr_en && hit_data;
    assign tx_data = wr_data;

    always_comb begin
        lsr.brk  = head.brk;
        lsr.ferr = head.ferr;
        lsr.perr = head.perr;
        lsr.ovr  = ovr;
        lsr.dr   = !empty;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_DATA: rd_data[DATA_W-1:0] = head.data;
            SEL_LSR:  rd_data[LSR_W-1:0]  = lsr;
            default:  rd_data = '0;
        endcase
    end

    a_r4_latch_blocks_access: assert property (@(posedge clk) disable iff (rst)
        dl_sel |-> (!pop && !tx_wr));

endmodule

// File: rtl/rx_holding_queue.sv
module rx_holding_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_clr,
    input  logic [1:0]        char_len,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              dl_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_byte,
    output logic              data_ready,
    output logic              overrun
);

    rx_entry_t in_entry;
    rx_entry_t head;
    logic      empty;
    logic      full;
    logic      drop;
    logic      pop;
    logic      lsr_rd;

    // short characters are cleared above their length on the way in
    always_comb begin
        in_entry.data = rx_data & len_mask(char_len);
        in_entry.perr = rx_perr;
        in_entry.ferr = rx_ferr;
        in_entry.brk  = rx_brk;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (fifo_clr),
        .push     (rx_valid),
        .wr_entry (in_entry),
        .pop      (pop),
        .head     (head),
        .empty    (empty),
        .full     (full),
        .drop     (drop)
    );

    rxq_overrun u_ovr (
        .clk    (clk),
        .rst    (rst),
        .drop   (drop),
        .lsr_rd (lsr_rd),
        .ovr    (overrun)
    );

    rxq_regport u_port (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (bus_rd),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .dl_sel  (dl_sel),
        .wr_data (bus_wdata),
        .head    (head),
        .empty   (empty),
        .ovr     (overrun),
        .rd_data (bus_rdata),
        .pop     (pop),
        .lsr_rd  (lsr_rd),
        .tx_wr   (tx_wr),
        .tx_data (tx_byte)
    );

    assign data_ready = !empty;

    a_r6_clear_drops_ready: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> !data_ready);

    a_r10_clear_keeps_ovr: assert property (@(posedge clk) disable iff (rst)
        (fifo_clr && !bus_rd) |=> (overrun == $past(overrun)));

endmodule

// File: tb/rx_holding_queue_test.sv
module rx_holding_queue_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        fifo_clr;
    logic [1:0]  char_len;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_perr, rx_ferr, rx_brk;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_addr;
    logic        dl_sel;
    logic [7:0]  bus_wdata;
    logic [31:0] bus_rdata;
    logic        tx_wr;
    logic [7:0]  tx_byte;
    logic        data_ready, overrun;

    always #10 clk = ~clk;   // 50 MHz

    rx_holding_queue uut (
        .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .char_len(char_len),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .dl_sel(dl_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .data_ready(data_ready), .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference queue
    logic [7:0] m_data [16];
    logic [2:0] m_st   [16];   // {brk, ferr, perr}
    int         m_head = 0;
    int         m_cnt  = 0;
    bit         m_ovr  = 0;

    function automatic logic [7:0] bmask(input logic [1:0] len);
        return 8'((9'd1 << (5 + len)) - 9'd1);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a, input bit dl);
        logic [31:0] v;
        v = '0;
        if (a == 8'h00 && !dl) begin
            if (m_cnt > 0) v[7:0] = m_data[m_head];
        end else if (a == 8'h14) begin
            v[0] = (m_cnt > 0);
            v[1] = m_ovr;
            if (m_cnt > 0) v[4:2] = m_st[m_head];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one cycle at the falling edge, check before the rising edge, then update the model
    task automatic step(input string tg, input bit clr, input bit push, input logic [7:0] d,
                        input logic [2:0] st, input bit rd, input bit wr,
                        input logic [7:0] a, input bit dl, input logic [1:0] len);
        bit pop_ok, drop;
        fifo_clr = clr; rx_valid = push; rx_data = d;
        {rx_brk, rx_ferr, rx_perr} = st;
        bus_rd = rd; bus_wr = wr; bus_addr = a; dl_sel = dl;
        bus_wdata = d ^ 8'h5a; char_len = len;
        #1;
        chk("R6 data_ready", {31'd0, data_ready}, {31'd0, (m_cnt > 0)});
        chk("R9 overrun", {31'd0, overrun}, {31'd0, m_ovr});
        if (rd) begin
            if (a == 8'h14)            chk({tg, " R5 status"}, bus_rdata, exp_read(a, dl));
            else if (dl)               chk({tg, " R4 locked read"}, bus_rdata, exp_read(a, dl));
            else if (m_cnt == 0)       chk({tg, " R11 empty read"}, bus_rdata, exp_read(a, dl));
            else                       chk({tg, " R2 data"}, bus_rdata, exp_read(a, dl));
        end
        chk("R4 tx strobe", {31'd0, tx_wr}, {31'd0, (wr && a == 8'h00 && !dl)});
        if (wr && a == 8'h00 && !dl) chk("R4 tx byte", {24'd0, tx_byte}, {24'd0, d ^ 8'h5a});
        @(posedge clk);
        pop_ok = rd && !dl && a == 8'h00 && m_cnt > 0 && !clr;
        drop   = push && !clr && m_cnt == 16 && !pop_ok;
        if (drop) m_ovr = 1;
        else if (rd && a == 8'h14) m_ovr = 0;
        if (clr) begin
            m_cnt = 0; m_head = 0;
        end else begin
            if (pop_ok) begin m_head = (m_head + 1) % 16; m_cnt--; end
            if (push && m_cnt < 16) begin
                m_data[(m_head + m_cnt) % 16] = d & bmask(len);
                m_st[(m_head + m_cnt) % 16]   = st;
                m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step("idle", 0, 0, 8'h00, 3'b000, 0, 0, 8'h08, 0, 2'd3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; fifo_clr = 0; char_len = 2'd3; rx_valid = 0; rx_data = 0;
        rx_perr = 0; rx_ferr = 0; rx_brk = 0; bus_rd = 0; bus_wr = 0;
        bus_addr = 0; dl_sel = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        bus_rd = 1; bus_addr = 8'h14; #1;
        chk("R1 status after reset", bus_rdata, 32'd0);
        chk("R1 data_ready", {31'd0, data_ready}, 32'd0);
        chk("R1 overrun", {31'd0, overrun}, 32'd0);
        bus_rd = 0;
        @(negedge clk);

        // R11: read of an empty queue
        step("R11", 0, 0, 8'h00, 3'b000, 1, 0, 8'h00, 0, 2'd3);

        // R3: each length code, upper bits forced high on input
        for (int k = 0; k < 4; k++)
            step("R3 push", 0, 1, 8'hff, 3'(k), 0, 0, 8'h08, 0, 2'(k));
        for (int k = 0; k < 4; k++) begin
            step("R3 status", 0, 0, 8'h00, 3'b000, 1, 0, 8'h14, 0, 2'd3);
            step("R3 data", 0, 0, 8'h00, 3'b000, 1, 0, 8'h00, 0, 2'd3);
        end

        // R7: fill to 16, then one more is dropped
        for (int k = 0; k < 16; k++)
            step("R7 fill", 0, 1, 8'(k * 7 + 1), 3'(k), 0, 0, 8'h08, 0, 2'd3);
        step("R7 extra", 0, 1, 8'hee, 3'b111, 0, 0, 8'h08, 0, 2'd3);
        idle();
        chk("R7 overrun set", {31'd0, overrun}, 32'd1);
        // R9: drop in the same cycle as the status read keeps the flag
        step("R9 collide", 0, 1, 8'hdd, 3'b000, 1, 0, 8'h14, 0, 2'd3);
        chk("R9 set wins", {31'd0, overrun}, 32'd1);
        step("R9 clear", 0, 0, 8'h00, 3'b000, 1, 0, 8'h14, 0, 2'd3);
        chk("R9 cleared", {31'd0, overrun}, 32'd0);

        // R8: arrival together with a read of a full queue
        step("R8 swap", 0, 1, 8'h3c, 3'b010, 1, 0, 8'h00, 0, 2'd3);
        chk("R8 no overrun", {31'd0, overrun}, 32'd0);

        // R4: divisor-latch select blocks the data register
        step("R4", 0, 0, 8'h00, 3'b000, 1, 0, 8'h00, 1, 2'd3);
        step("R4", 0, 0, 8'h11, 3'b000, 0, 1, 8'h00, 1, 2'd3);
        step("R4", 0, 0, 8'h22, 3'b000, 0, 1, 8'h00, 0, 2'd3);

        // drain and verify order
        for (int k = 0; k < 16; k++)
            step("R2 drain", 0, 0, 8'h00, 3'b000, 1, 0, 8'h00, 0, 2'd3);
        chk("R6 empty after drain", {31'd0, data_ready}, 32'd0);

        // R10: clear with a same-cycle arrival
        for (int k = 0; k < 5; k++)
            step("R10 fill", 0, 1, 8'(k + 40), 3'b001, 0, 0, 8'h08, 0, 2'd3);
        step("R10 clear", 1, 1, 8'h77, 3'b000, 0, 0, 8'h08, 0, 2'd3);
        chk("R10 empty", {31'd0, data_ready}, 32'd0);
        chk("R10 no overrun", {31'd0, overrun}, 32'd0);
        step("R10 after", 0, 0, 8'h00, 3'b000, 1, 0, 8'h14, 0, 2'd3);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r_a;
            logic [7:0] a;
            r_a = $urandom_range(0, 9);
            a = (r_a < 6) ? 8'h00 : (r_a < 9) ? 8'h14 : 8'h08;
            step("rand", ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 55),
                 8'($urandom), 3'($urandom), ($urandom_range(0, 99) < 45),
                 ($urandom_range(0, 99) < 10), a, ($urandom_range(0, 99) < 8),
                 2'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule